// File: doc/BRIEF.md
# PCI Function Life-Cycle Controller

This block keeps the life-cycle state of a small set of PCI function slots that sit behind a host bridge. Every slot holds one of five states: reserved, standby, disabled, enabled or blocked. It also holds a function identifier and the enable bit of the function handle. A single command port carries all requests. Configure and deconfigure are looked up by identifier. Create, plug, hot plug, unplug, enable and block are addressed by slot number. A reset command applies to every slot at once.

Configure and deconfigure each get a 4-bit response code, registered and shown for one cycle. Availability events leave through a valid/ready stream, backed by a small queue. When a slot that is still in use is unplugged, the block posts a deconfigure request and starts a per-slot release timer. When that timer runs out, the block forces the slot back and posts a second event. Releasing interrupts and translation is the job of neighbouring logic. That logic sees only a one-cycle strobe mask.

The command port applies back-pressure. `cmd_ready` is high only while the event queue has at least two free entries, so one command event and one timer event always fit in the same cycle. The event stream follows the usual handshake. An entry leaves the queue on a cycle where `evt_valid` and `evt_ready` are both high. While it is not taken, the head entry stays on the outputs unchanged.

Top module: `pcifn_cfg_fsm`

## Requirements
- R1: After reset every slot reads reserved (state code 0 in `fn_state[3i+2:3i]`; the other codes are standby 1, disabled 2, enabled 3, blocked 4), `fn_en` is zero and no event or response is shown. Op 0 (create) marks the slot present with `cmd_fid`, sets it to reserved, clears its enable bit and cancels its timer. Every op that takes a slot number has no effect on a slot that was never created.
- R2: Op 1 (configure, keyed by `cmd_fid`; the lowest present slot whose identifier matches wins) responds one cycle after acceptance. An unknown identifier gives code 2 and a reserved slot gives code 3. A standby slot moves to disabled and gives code 1 (normal). Any other state gives code 4 (no action).
- R3: Op 2 (deconfigure) gives code 2 for an unknown identifier, code 3 for a reserved slot and code 4 for a standby slot. From disabled, enabled or blocked it moves the slot to standby, clears its enable bit, gives code 1 and pulses that slot's bit in `rel_mask` in the same cycle as the response.
- R4: Op 3 (plug) and op 4 (hot plug) move the slot to disabled and clear its enable bit. Hot plug also posts event kind 1 (reserved-to-standby) carrying the slot and its identifier.
- R5: Op 7 (enable) moves a disabled slot to enabled and sets its enable bit. Op 8 (block) moves an enabled slot to blocked. In any other state both ops are ignored.
- R6: Op 5 (unplug) on a disabled, enabled or blocked slot posts event kind 2 (deconfigure request) and starts the release timer, and leaves the state unchanged. A second unplug while the timer is running posts nothing. A configure while the timer is running does not stop it.
- R7: The timer expires on the RELEASE_CYCLES-th clock edge after the edge that accepted the unplug. At that edge the slot becomes reserved, its enable bit clears, its `rel_mask` bit pulses and event kind 3 (forced release) is posted.
- R8: Unplug of a standby slot cancels any running timer, posts event kind 4 (standby-to-reserved) and moves the slot to reserved. Unplug of a reserved slot does nothing.
- R9: Op 6 (reset) moves every disabled, enabled or blocked slot to disabled and clears all enable bits. Reserved and standby slots keep their states.
- R10: Events leave in posting order. A command's event is queued ahead of a timer event from the same cycle, and an unaccepted head entry stays stable. `cmd_ready` is low whenever fewer than two queue entries are free.
- R11: A timer expiry and an accepted command that targets a different slot both take full effect in the same cycle. An expiry is deferred by at least one cycle when the accepted command targets the same slot or is a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 4 | Operation code |
| cmd_slot | input | $clog2(FUNCS) | Target slot for slot-addressed ops |
| cmd_fid | input | FID_W | Identifier for create, configure, deconfigure |
| rsp_valid | output | 1 | Response shown for one cycle |
| rsp_code | output | 4 | Response code |
| rel_mask | output | FUNCS | One-cycle release strobes, one bit per slot |
| evt_valid | output | 1 | Event queue head is valid |
| evt_ready | input | 1 | Consumer takes the head event |
| evt_kind | output | 3 | Event kind |
| evt_slot | output | $clog2(FUNCS) | Slot of the event |
| evt_fid | output | FID_W | Identifier of the event's slot |
| fn_state | output | 3*FUNCS | Packed slot states |
| fn_en | output | FUNCS | Handle enable bits |

## Verification
A release timer can expire in the same cycle that a command is accepted, so these two functions can coincide. The bench counts clock edges from the edge that accepted the unplug and presents a command that is accepted exactly on the expiry edge. In one case the command is a hot plug of another slot. There the check is that both state changes, the single release strobe and the two events all appear in the stated order. In the other case the command is an enable of the expiring slot itself. There the check is that the enable lands first and the forced release follows one cycle later.

// File: rtl/pcifn_pkg.sv
package pcifn_pkg;
  typedef enum logic [2:0] {
    FS_RESERVED = 3'd0,
    FS_STANDBY  = 3'd1,
    FS_DISABLED = 3'd2,
    FS_ENABLED  = 3'd3,
    FS_BLOCKED  = 3'd4
  } fn_state_e;

  typedef enum logic [3:0] {
    OP_CREATE   = 4'd0,
    OP_CONFIG   = 4'd1,
    OP_DECONFIG = 4'd2,
    OP_PLUG     = 4'd3,
    OP_HOTPLUG  = 4'd4,
    OP_UNPLUG   = 4'd5,
    OP_RESET    = 4'd6,
    OP_ENABLE   = 4'd7,
    OP_BLOCK    = 4'd8
  } op_e;

  localparam logic [3:0] RC_NORMAL   = 4'd1;
  localparam logic [3:0] RC_UNKNOWN  = 4'd2;
  localparam logic [3:0] RC_RESERVED = 4'd3;
  localparam logic [3:0] RC_NOACTION = 4'd4;

  localparam logic [2:0] EV_RES_TO_STBY = 3'd1;
  localparam logic [2:0] EV_DECONF_REQ  = 3'd2;
  localparam logic [2:0] EV_FORCED_REL  = 3'd3;
  localparam logic [2:0] EV_STBY_TO_RES = 3'd4;
endpackage

// File: rtl/pcifn_fid_match.sv
module pcifn_fid_match #(
  parameter int FUNCS  = 8,
  parameter int FID_W  = 8,
  parameter int SLOT_W = 3
) (
  input  logic [FUNCS*FID_W-1:0] fid_tab,
  input  logic [FUNCS-1:0]       present,
  input  logic [FID_W-1:0]       key,
  output logic                   hit,
  output logic [SLOT_W-1:0]      slot
);
  // Scan from the top so the lowest matching slot is the one left standing.
  always_comb begin
    hit  = 1'b0;
    slot = '0;
    for (int i = FUNCS - 1; i >= 0; i--) begin
      if (present[i] && fid_tab[i*FID_W +: FID_W] == key) begin
        hit  = 1'b1;
        slot = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/pcifn_release_timer.sv
module pcifn_release_timer #(
  parameter int FUNCS  = 8,
  parameter int CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FUNCS-1:0] start,
  input  logic [FUNCS-1:0] cancel,
  input  logic [FUNCS-1:0] fire,
  output logic [FUNCS-1:0] pending,
  output logic [FUNCS-1:0] due
);
  localparam int CW = $clog2(CYCLES + 1);

  for (genvar g = 0; g < FUNCS; g++) begin : g_slot
    logic [CW-1:0] cnt;
    logic          pend;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend <= 1'b0;
        cnt  <= '0;
      end else if (cancel[g] || fire[g]) begin
        pend <= 1'b0;
        cnt  <= '0;
      end else if (start[g]) begin
        pend <= 1'b1;
        cnt  <= CW'(CYCLES - 1);
      end else if (pend && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign pending[g] = pend;
    assign due[g]     = pend && (cnt == '0);
  end
endmodule

// File: rtl/pcifn_evq.sv
module pcifn_evq #(
  parameter int DEPTH = 8,
  parameter int W     = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_a,
  input  logic [W-1:0]               din_a,
  input  logic                       push_b,
  input  logic [W-1:0]               din_b,
  input  logic                       pop,
  output logic                       valid,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] free
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp, wp_b;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wp_b  = push_a ? step(wp) : wp;
  assign valid = (count != '0);
  assign dout  = mem[rp];
  assign free  = CW'(DEPTH) - count;

  always_ff @(posedge clk) begin
    if (push_a) mem[wp] <= din_a;
    if (push_b) mem[wp_b] <= din_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      if (push_b)      wp <= step(wp_b);
      else if (push_a) wp <= step(wp);
      if (pop) rp <= step(rp);
      count <= count + CW'(push_a) + CW'(push_b) - CW'(pop);
    end
  end
endmodule

// File: rtl/pcifn_cfg_fsm.sv
module pcifn_cfg_fsm
  import pcifn_pkg::*;
#(
  parameter int FUNCS          = 8,
  parameter int FID_W          = 8,
  parameter int RELEASE_CYCLES = 4096,
  parameter int EVQ_DEPTH      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [3:0]                 cmd_op,
  input  logic [$clog2(FUNCS)-1:0]   cmd_slot,
  input  logic [FID_W-1:0]           cmd_fid,
  output logic                       rsp_valid,
  output logic [3:0]                 rsp_code,
  output logic [FUNCS-1:0]           rel_mask,
  output logic                       evt_valid,
  input  logic                       evt_ready,
  output logic [2:0]                 evt_kind,
  output logic [$clog2(FUNCS)-1:0]   evt_slot,
  output logic [FID_W-1:0]           evt_fid,
  output logic [3*FUNCS-1:0]         fn_state,
  output logic [FUNCS-1:0]           fn_en
);
  localparam int SLOT_W = $clog2(FUNCS);
  localparam int EW     = 3 + SLOT_W + FID_W;
  localparam int QCW    = $clog2(EVQ_DEPTH + 1);

  fn_state_e         st_q [FUNCS];
  fn_state_e         st_d [FUNCS];
  logic [FID_W-1:0]  fid_q [FUNCS];
  logic [FID_W-1:0]  fid_d [FUNCS];
  logic [FUNCS-1:0]  ex_q, ex_d, en_q, en_d;
  logic [FUNCS*FID_W-1:0] fid_flat;

  logic              hit;
  logic [SLOT_W-1:0] mslot, tslot, xslot;
  logic              xany, xgo, defer, acc;
  op_e               op;
  fn_state_e         cur;

  logic [FUNCS-1:0]  t_start, t_cancel, t_fire, t_pend, t_due;
  logic              push_a, push_b;
  logic [EW-1:0]     din_a, din_b, qdout;
  logic [QCW-1:0]    evq_free;
  logic              rsp_v_d;
  logic [3:0]        rsp_c_d;
  logic [FUNCS-1:0]  rel_d;

  for (genvar g = 0; g < FUNCS; g++) begin : g_flat
    assign fid_flat[g*FID_W +: FID_W] = fid_q[g];
    assign fn_state[3*g +: 3]         = st_q[g];
  end
  assign fn_en = en_q;

  pcifn_fid_match #(.FUNCS(FUNCS), .FID_W(FID_W), .SLOT_W(SLOT_W)) u_match (
    .fid_tab(fid_flat), .present(ex_q), .key(cmd_fid), .hit(hit), .slot(mslot)
  );

  pcifn_release_timer #(.FUNCS(FUNCS), .CYCLES(RELEASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(t_start), .cancel(t_cancel),
    .fire(t_fire), .pending(t_pend), .due(t_due)
  );

  pcifn_evq #(.DEPTH(EVQ_DEPTH), .W(EW)) u_evq (
    .clk(clk), .rst_n(rst_n), .push_a(push_a), .din_a(din_a),
    .push_b(push_b), .din_b(din_b), .pop(evt_valid && evt_ready),
    .valid(evt_valid), .dout(qdout), .free(evq_free)
  );
  assign {evt_kind, evt_slot, evt_fid} = qdout;

  // Room for one command event plus one timer event is required up front.
  assign cmd_ready = (evq_free >= QCW'(2));
  assign acc       = cmd_valid && cmd_ready;
  assign op        = op_e'(cmd_op);
  assign tslot     = (op == OP_CONFIG || op == OP_DECONFIG) ? mslot : cmd_slot;
  assign cur       = st_q[tslot];

  // Lowest expired slot is served first.
  always_comb begin
    xany  = 1'b0;
    xslot = '0;
    for (int i = FUNCS - 1; i >= 0; i--) begin
      if (t_due[i]) begin
        xany  = 1'b1;
        xslot = SLOT_W'(i);
      end
    end
  end

  assign defer = acc && (op == OP_RESET || tslot == xslot);
  assign xgo   = xany && !defer && cmd_ready;

  always_comb begin
    st_d     = st_q;
    fid_d    = fid_q;
    ex_d     = ex_q;
    en_d     = en_q;
    t_start  = '0;
    t_cancel = '0;
    t_fire   = '0;
    push_a   = 1'b0;
    din_a    = '0;
    push_b   = 1'b0;
    din_b    = '0;
    rsp_v_d  = 1'b0;
    rsp_c_d  = '0;
    rel_d    = '0;

    if (acc) begin
      case (op)
        OP_CREATE: begin
          ex_d[tslot]     = 1'b1;
          fid_d[tslot]    = cmd_fid;
          st_d[tslot]     = FS_RESERVED;
          en_d[tslot]     = 1'b0;
          t_cancel[tslot] = 1'b1;
        end
        OP_CONFIG: begin
          rsp_v_d = 1'b1;
          if (!hit)                     rsp_c_d = RC_UNKNOWN;
          else if (cur == FS_RESERVED)  rsp_c_d = RC_RESERVED;
          else if (cur == FS_STANDBY) begin
            st_d[tslot] = FS_DISABLED;
            rsp_c_d     = RC_NORMAL;
          end else                      rsp_c_d = RC_NOACTION;
        end
        OP_DECONFIG: begin
          rsp_v_d = 1'b1;
          if (!hit)                     rsp_c_d = RC_UNKNOWN;
          else if (cur == FS_RESERVED)  rsp_c_d = RC_RESERVED;
          else if (cur == FS_STANDBY)   rsp_c_d = RC_NOACTION;
          else begin
            st_d[tslot]  = FS_STANDBY;
            en_d[tslot]  = 1'b0;
            rel_d[tslot] = 1'b1;
            rsp_c_d      = RC_NORMAL;
          end
        end
        OP_PLUG, OP_HOTPLUG: begin
          if (ex_q[tslot]) begin
            st_d[tslot] = FS_DISABLED;
            en_d[tslot] = 1'b0;
            if (op == OP_HOTPLUG) begin
              push_a = 1'b1;
              din_a  = {EV_RES_TO_STBY, tslot, fid_q[tslot]};
            end
          end
        end
        OP_UNPLUG: begin
          if (ex_q[tslot]) begin
            if (cur == FS_STANDBY) begin
              t_cancel[tslot] = 1'b1;
              st_d[tslot]     = FS_RESERVED;
              push_a          = 1'b1;
              din_a           = {EV_STBY_TO_RES, tslot, fid_q[tslot]};
            end else if (cur != FS_RESERVED && !t_pend[tslot]) begin
              t_start[tslot] = 1'b1;
              push_a         = 1'b1;
              din_a          = {EV_DECONF_REQ, tslot, fid_q[tslot]};
            end
          end
        end
        OP_RESET: begin
          for (int i = 0; i < FUNCS; i++) begin
            if (st_q[i] == FS_DISABLED || st_q[i] == FS_ENABLED ||
                st_q[i] == FS_BLOCKED)
              st_d[i] = FS_DISABLED;
          end
          en_d = '0;
        end
        OP_ENABLE: begin
          if (ex_q[tslot] && cur == FS_DISABLED) begin
            st_d[tslot] = FS_ENABLED;
            en_d[tslot] = 1'b1;
          end
        end
        OP_BLOCK: begin
          if (ex_q[tslot] && cur == FS_ENABLED) st_d[tslot] = FS_BLOCKED;
        end
        default: ;
      endcase
    end

    // Forced release of an expired slot, never the slot the command touched.
    if (xgo) begin
      st_d[xslot]   = FS_RESERVED;
      en_d[xslot]   = 1'b0;
      rel_d[xslot]  = 1'b1;
      t_fire[xslot] = 1'b1;
      push_b        = 1'b1;
      din_b         = {EV_FORCED_REL, xslot, fid_q[xslot]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FUNCS; i++) begin
        st_q[i]  <= FS_RESERVED;
        fid_q[i] <= '0;
      end
      ex_q      <= '0;
      en_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rel_mask  <= '0;
    end else begin
      st_q      <= st_d;
      fid_q     <= fid_d;
      ex_q      <= ex_d;
      en_q      <= en_d;
      rsp_valid <= rsp_v_d;
      rsp_code  <= rsp_c_d;
      rel_mask  <= rel_d;
    end
  end
endmodule

// File: rtl/pcifn_cfg_fsm_chk.sv
module pcifn_cfg_fsm_chk #(
  parameter int FUNCS     = 8,
  parameter int FID_W     = 8,
  parameter int EVQ_DEPTH = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_valid,
  input logic                         cmd_ready,
  input logic [3:0]                   cmd_op,
  input logic                         rsp_valid,
  input logic                         evt_valid,
  input logic                         evt_ready,
  input logic [2:0]                   evt_kind,
  input logic [$clog2(FUNCS)-1:0]     evt_slot,
  input logic [FID_W-1:0]             evt_fid,
  input logic [3*FUNCS-1:0]           fn_state,
  input logic [FUNCS-1:0]             fn_en,
  input logic [$clog2(EVQ_DEPTH+1)-1:0] q_free
);
  logic             acc, is_cfg;
  logic [FUNCS-1:0] active, illegal;

  assign acc    = cmd_valid && cmd_ready;
  assign is_cfg = (cmd_op == 4'd1) || (cmd_op == 4'd2);

  always_comb begin
    for (int i = 0; i < FUNCS; i++) begin
      active[i]  = (fn_state[3*i +: 3] == 3'd3) || (fn_state[3*i +: 3] == 3'd4);
      illegal[i] = (fn_state[3*i +: 3] > 3'd4);
    end
  end

  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    illegal == '0);

  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_cfg) |=> rsp_valid);

  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && is_cfg) |=> !rsp_valid);

  a_r5_en_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_en & ~active) == '0);

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 4'd6) |=> (active == '0 && fn_en == '0));

  a_r10_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_kind) &&
                                   $stable(evt_slot) && $stable(evt_fid)));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_free <= ($clog2(EVQ_DEPTH+1))'(EVQ_DEPTH));
endmodule

bind pcifn_cfg_fsm pcifn_cfg_fsm_chk #(
  .FUNCS(FUNCS), .FID_W(FID_W), .EVQ_DEPTH(EVQ_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .evt_valid(evt_valid),
  .evt_ready(evt_ready), .evt_kind(evt_kind), .evt_slot(evt_slot),
  .evt_fid(evt_fid), .fn_state(fn_state), .fn_en(fn_en), .q_free(evq_free)
);

// File: tb/pcifn_cfg_fsm_bench.sv
module pcifn_cfg_fsm_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int T = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_slot = '0;
  logic [7:0]  cmd_fid = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_code;
  logic [7:0]  rel_mask;
  logic        evt_valid;
  logic        evt_ready = 1'b0;
  logic [2:0]  evt_kind;
  logic [2:0]  evt_slot;
  logic [7:0]  evt_fid;
  logic [23:0] fn_state;
  logic [7:0]  fn_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_acc = 0;

  pcifn_cfg_fsm #(.FUNCS(8), .FID_W(8), .RELEASE_CYCLES(T), .EVQ_DEPTH(4)) u_pcifn_cfg_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_fid(cmd_fid),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rel_mask(rel_mask),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
    .evt_slot(evt_slot), .evt_fid(evt_fid), .fn_state(fn_state), .fn_en(fn_en)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] stv(input int i);
    return fn_state[3*i +: 3];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic issue(input logic [3:0] op, input logic [2:0] slot, input logic [7:0] fid);
    cmd_op = op; cmd_slot = slot; cmd_fid = fid; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    last_acc = cyc;
  endtask

  task automatic pop(input string req, input logic [2:0] kind, input logic [2:0] slot, input logic [7:0] fid);
    check(req, {17'd0, evt_valid, evt_kind, evt_slot, evt_fid}, {17'd0, 1'b1, kind, slot, fid});
    evt_ready = 1'b1;
    @(negedge clk);
    evt_ready = 1'b0;
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic t_reset_state;
    check("R1 states", {8'd0, fn_state}, 32'd0);
    check("R1 enables", {24'd0, fn_en}, 32'd0);
    check("R1 idle outputs", {29'd0, evt_valid, rsp_valid, cmd_ready}, 32'd1);
    issue(4'd4, 3'd7, 8'h00);
    check("R1 absent slot hotplug", {31'd0, evt_valid}, 32'd0);
    for (int i = 0; i < 8; i++) issue(4'd0, 3'(i), 8'h10 + 8'(i));
    check("R1 created reserved", {8'd0, fn_state}, 32'd0);
  endtask

  task automatic t_codes_reserved;
    issue(4'd1, 3'd0, 8'h99);
    check("R2 unknown", {27'd0, rsp_valid, rsp_code}, {27'd0, 1'b1, 4'd2});
    issue(4'd1, 3'd0, 8'h10);
    check("R2 reserved", {27'd0, rsp_valid, rsp_code}, {27'd0, 1'b1, 4'd3});
    issue(4'd2, 3'd0, 8'h10);
    check("R3 reserved", {28'd0, rsp_code}, 32'd3);
    issue(4'd2, 3'd0, 8'h77);
    check("R3 unknown", {28'd0, rsp_code}, 32'd2);
    @(negedge clk);
    check("R2 response one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_plug_cfg;
    issue(4'd4, 3'd0, 8'h00);
    check("R4 hotplug state", {29'd0, stv(0)}, 32'd2);
    pop("R4 hotplug event", 3'd1, 3'd0, 8'h10);
    issue(4'd3, 3'd1, 8'h00);
    check("R4 plug state/no event", {28'd0, evt_valid, stv(1)}, 32'd2);
    issue(4'd1, 3'd0, 8'h11);
    check("R2 no action", {28'd0, rsp_code}, 32'd4);
    issue(4'd2, 3'd0, 8'h11);
    check("R3 deconfig normal", {20'd0, rel_mask, rsp_code}, {20'd0, 8'h02, 4'd1});
    check("R3 to standby", {29'd0, stv(1)}, 32'd1);
    issue(4'd1, 3'd0, 8'h11);
    check("R2 standby to disabled", {25'd0, stv(1), rsp_code}, {25'd0, 3'd2, 4'd1});
    issue(4'd2, 3'd0, 8'h11);
    issue(4'd2, 3'd0, 8'h11);
    check("R3 standby no action", {25'd0, stv(1), rsp_code}, {25'd0, 3'd1, 4'd4});
  endtask

  task automatic t_enable_block_reset;
    issue(4'd7, 3'd0, 8'h00);
    check("R5 enable", {28'd0, stv(0), fn_en[0]}, {28'd0, 3'd3, 1'b1});
    issue(4'd8, 3'd0, 8'h00);
    check("R5 block", {28'd0, stv(0), fn_en[0]}, {28'd0, 3'd4, 1'b1});
    issue(4'd7, 3'd1, 8'h00);
    check("R5 enable ignored", {28'd0, stv(1), fn_en[1]}, {28'd0, 3'd1, 1'b0});
    issue(4'd6, 3'd0, 8'h00);
    check("R9 reset states", {23'd0, stv(0), stv(1), stv(2)}, {23'd0, 3'd2, 3'd1, 3'd0});
    check("R9 reset enables", {24'd0, fn_en}, 32'd0);
  endtask

  task automatic t_unplug_timeout;
    int e;
    issue(4'd5, 3'd0, 8'h00);
    e = last_acc;
    check("R6 state kept", {29'd0, stv(0)}, 32'd2);
    pop("R6 deconfig request", 3'd2, 3'd0, 8'h10);
    issue(4'd1, 3'd0, 8'h10);
    check("R6 config while pending", {28'd0, rsp_code}, 32'd4);
    issue(4'd5, 3'd0, 8'h00);
    check("R6 repeat unplug silent", {31'd0, evt_valid}, 32'd0);
    wait_cyc(e + T - 1);
    check("R7 not yet", {29'd0, stv(0)}, 32'd2);
    @(negedge clk);
    check("R7 forced release", {21'd0, stv(0), rel_mask}, {21'd0, 3'd0, 8'h01});
    pop("R7 release event", 3'd3, 3'd0, 8'h10);
  endtask

  task automatic t_standby_unplug;
    int e;
    issue(4'd3, 3'd3, 8'h00);
    issue(4'd5, 3'd3, 8'h00);
    e = last_acc;
    pop("R6 deconfig request s3", 3'd2, 3'd3, 8'h13);
    issue(4'd2, 3'd0, 8'h13);
    check("R3 release strobe s3", {24'd0, rel_mask}, 32'h08);
    issue(4'd5, 3'd3, 8'h00);
    check("R8 to reserved", {29'd0, stv(3)}, 32'd0);
    pop("R8 standby event", 3'd4, 3'd3, 8'h13);
    issue(4'd5, 3'd2, 8'h00);
    check("R8 reserved unplug", {28'd0, evt_valid, stv(2)}, 32'd0);
    wait_cyc(e + T + 3);
    check("R8 timer cancelled", {20'd0, evt_valid, stv(3), rel_mask}, 32'd0);
  endtask

  task automatic t_coincide;
    int e;
    issue(4'd3, 3'd4, 8'h00);
    issue(4'd3, 3'd5, 8'h00);
    issue(4'd5, 3'd4, 8'h00);
    e = last_acc;
    pop("R6 deconfig request s4", 3'd2, 3'd4, 8'h14);
    wait_cyc(e + T - 1);
    issue(4'd4, 3'd5, 8'h00);
    check("R11 accepted at expiry edge", last_acc, e + T);
    check("R11 both states", {26'd0, stv(4), stv(5)}, {26'd0, 3'd0, 3'd2});
    check("R11 one strobe", {24'd0, rel_mask}, 32'h10);
    pop("R10 command event first", 3'd1, 3'd5, 8'h15);
    pop("R10 timer event second", 3'd3, 3'd4, 8'h14);
    issue(4'd3, 3'd6, 8'h00);
    issue(4'd5, 3'd6, 8'h00);
    e = last_acc;
    pop("R6 deconfig request s6", 3'd2, 3'd6, 8'h16);
    wait_cyc(e + T - 1);
    issue(4'd7, 3'd6, 8'h00);
    check("R11 same slot enable first", {28'd0, stv(6), fn_en[6]}, {28'd0, 3'd3, 1'b1});
    @(negedge clk);
    check("R11 deferred release", {20'd0, stv(6), fn_en[6], rel_mask}, {20'd0, 3'd0, 1'b0, 8'h40});
    pop("R7 deferred event", 3'd3, 3'd6, 8'h16);
  endtask

  task automatic t_backpressure;
    issue(4'd4, 3'd1, 8'h00);
    issue(4'd4, 3'd2, 8'h00);
    issue(4'd4, 3'd3, 8'h00);
    check("R10 ready low", {31'd0, cmd_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    pop("R10 head held s1", 3'd1, 3'd1, 8'h11);
    check("R10 ready back", {31'd0, cmd_ready}, 32'd1);
    pop("R10 order s2", 3'd1, 3'd2, 8'h12);
    pop("R10 order s3", 3'd1, 3'd3, 8'h13);
    check("R10 drained", {31'd0, evt_valid}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_codes_reserved();
    t_plug_cfg();
    t_enable_block_reset();
    t_unplug_timeout();
    t_standby_unplug();
    t_coincide();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule